// File: doc/BRIEF.md
# Free-Running Timer Counter with Prescaler

This block is a 16-bit up-counting timer that never stops. Each count step comes from one of two sources. The first is the system clock divided by 2, 4 or 8. The second is an edge of an external clock pin, where the edge is programmable. When the count passes from FFFFh to 0000h, an overflow flag is set, and the overflow drives an interrupt line that can be masked.

Software reaches the block over an 8-bit register bus. The count can be read through two byte pairs, a main pair and an alternate pair. Both pairs return the same value. Only a low-byte read of the main pair can take part in clearing the overflow flag. A read of either high byte saves the matching low byte, so a high-then-low read returns one consistent 16-bit value. A write of any data to either low-byte address restarts the count at FFFCh and restarts the divider.

Top module: `frt_timer`

Register map (byte addresses):
- 0: control. Bits [1:0] select the clock source, bit 2 selects the external edge, bit 3 enables the interrupt. All 8 bits read back.
- 1: status. TOF is bit 7. The other bits read as 0.
- 2 and 3: main high and low bytes.
- 4 and 5: alternate high and low bytes.

Unmapped addresses read as 0.

## Requirements
- R1: The count only increments, by one per step, and wraps from FFFFh to 0000h. Between steps it holds its value.
- R2: Clock select codes (control bits [1:0]): 00 divides the clock by 4, 01 divides by 2, 10 divides by 8. After a restart the count reads FFFCh + floor(k/n) k cycles later, where n is the divide ratio.
- R3: Clock select code 11 steps the count on edges of the external pin. Control bit 2 = 1 counts rising edges and 0 counts falling edges. The pin passes through a two-stage synchronizer, so a step lands three clock edges after the pin changes.
- R4: When the parameter EXT_PRESENT is 0, the external pin reads as constant 1, so external mode never advances the count.
- R5: A write to address 3 or address 5 sets the count to FFFCh and clears the divider. Reset also loads FFFCh, clears control to 00h and clears TOF.
- R6: The main pair (2, 3) and the alternate pair (4, 5) return the same count. Read data appears on the clock edge that samples the read strobe and holds until the next read.
- R7: TOF (status bit 7) is set on the clock edge where the count wraps to 0000h.
- R8: TOF clears only when a status read that sees TOF = 1 is followed by a read of address 3. A read of address 5 never clears TOF.
- R9: If a wrap occurs between that status read and the address-3 read, TOF stays set.
- R10: The interrupt output equals TOF AND control bit 3, and both are registered in the same cycle.
- R11: A read of address 2 (or 4) saves the current low byte. The next read of address 3 (or 5) returns that saved byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_clk_pin | input | 1 | External count clock |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Every result is tied to the index of the clock edge that caused it, and the bench tracks these indices.
- **Count after a restart:** the count is FFFCh + floor(k/n) one edge after the restart edge plus k.
- **Read data:** the value latched at the read edge is the count from one edge earlier, so the expected value uses read edge minus one.
- **External mode:** the pin is held for at least four cycles between changes, and the count is checked only after the three-edge synchronizer delay has passed.
- **Flag and interrupt:** TOF and the interrupt are sampled on the falling edge that follows the edge where they change.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MAIN_H = 3'd2;
  localparam logic [ADDR_W-1:0] A_MAIN_L = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALT_H  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ALT_L  = 3'd5;

  typedef enum logic [1:0] {
    CS_DIV4 = 2'b00,
    CS_DIV2 = 2'b01,
    CS_DIV8 = 2'b10,
    CS_EXT  = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/frt_tick_gen.sv
module frt_tick_gen
  import frt_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int EXT_PRESENT = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e clk_sel,
  input  logic     ext_rise,
  input  logic     ext_pin,
  input  logic     restart,
  output logic     tick
);
  localparam logic FORCE_HI = (EXT_PRESENT == 0);

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] limit;
  logic            pin_v;
  logic            sync1, sync2, prev;
  logic            ext_edge;

  assign pin_v = ext_pin | FORCE_HI;

  always_comb begin
    unique case (clk_sel)
      CS_DIV2: limit = PS_W'(1);
      CS_DIV8: limit = PS_W'(7);
      default: limit = PS_W'(3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= pin_v;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign ext_edge = ext_rise ? (sync2 & ~prev) : (~sync2 & prev);

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (clk_sel != CS_EXT) pcnt <= (pcnt >= limit) ? '0 : pcnt + 1'b1;
  end

  assign tick = (clk_sel == CS_EXT) ? ext_edge : (pcnt >= limit);

  // internal divider never ticks on two consecutive edges
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && clk_sel != CS_EXT && !restart) |=> (!tick || clk_sel == CS_EXT));
endmodule

// File: rtl/frt_count.sv
module frt_count #(
  parameter int          CNT_W  = 16,
  parameter logic [15:0] RELOAD = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst || reload) count <= CNT_W'(RELOAD);
    else if (tick)     count <= count + 1'b1;
  end

  assign wrap = tick && !reload && (&count);

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    reload |=> (count == CNT_W'(RELOAD)));
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !reload) |=> $stable(count));
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (count == '0));
endmodule

// File: rtl/frt_regs.sv
module frt_regs
  import frt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  input  logic [15:0]       count,
  input  logic              wrap,
  output logic [7:0]        rdata,
  output logic              irq,
  output clk_sel_e          clk_sel,
  output logic              ext_rise,
  output logic              reload
);
  logic [7:0] ctrl, ctrl_d;
  logic       tof, tof_d, armed, armed_d;
  logic [7:0] shd_main, shd_alt;
  logic       shd_main_v, shd_alt_v;

  assign reload   = wr_en && (addr == A_MAIN_L || addr == A_ALT_L);
  assign clk_sel  = clk_sel_e'(ctrl[1:0]);
  assign ext_rise = ctrl[2];

  always_comb begin
    ctrl_d = ctrl;
    if (wr_en && addr == A_CTRL) ctrl_d = wdata;
  end

  always_comb begin
    tof_d   = tof;
    armed_d = armed;
    if (wrap) begin
      tof_d   = 1'b1;
      armed_d = 1'b0;
    end else if (rd_en && addr == A_MAIN_L && armed) begin
      tof_d   = 1'b0;
      armed_d = 1'b0;
    end else if (rd_en && addr == A_STAT && tof) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      tof   <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ctrl  <= ctrl_d;
      tof   <= tof_d;
      armed <= armed_d;
      irq   <= tof_d & ctrl_d[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      shd_main   <= '0;
      shd_alt    <= '0;
      shd_main_v <= 1'b0;
      shd_alt_v  <= 1'b0;
    end else begin
      if (reload) begin
        shd_main_v <= 1'b0;
        shd_alt_v  <= 1'b0;
      end
      if (rd_en) begin
        unique case (addr)
          A_CTRL: rdata <= ctrl;
          A_STAT: rdata <= {tof, 7'b0};
          A_MAIN_H: begin
            rdata      <= count[15:8];
            shd_main   <= count[7:0];
            shd_main_v <= 1'b1;
          end
          A_MAIN_L: begin
            rdata      <= shd_main_v ? shd_main : count[7:0];
            shd_main_v <= 1'b0;
          end
          A_ALT_H: begin
            rdata     <= count[15:8];
            shd_alt   <= count[7:0];
            shd_alt_v <= 1'b1;
          end
          A_ALT_L: begin
            rdata     <= shd_alt_v ? shd_alt : count[7:0];
            shd_alt_v <= 1'b0;
          end
          default: rdata <= '0;
        endcase
      end
    end
  end

  p_wrap_sets_tof_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> tof);
  p_alt_keeps_tof_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_ALT_L && tof) |=> tof);
  p_irq_needs_tof_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> tof);
endmodule

// File: rtl/frt_timer.sv
module frt_timer
  import frt_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int EXT_PRESENT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_clk_pin,
  output logic              irq_ovf
);
  localparam int CNT_W = 16;

  clk_sel_e         sel;
  logic             ext_rise, reload, tick, wrap;
  logic [CNT_W-1:0] count;

  frt_regs u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
    .wdata(bus_wdata), .count(count), .wrap(wrap), .rdata(bus_rdata),
    .irq(irq_ovf), .clk_sel(sel), .ext_rise(ext_rise), .reload(reload)
  );

  frt_tick_gen #(.PS_W(PS_W), .EXT_PRESENT(EXT_PRESENT)) u_tick (
    .clk(clk), .rst(rst), .clk_sel(sel), .ext_rise(ext_rise),
    .ext_pin(ext_clk_pin), .restart(reload), .tick(tick)
  );

  frt_count #(.CNT_W(CNT_W), .RELOAD(16'hFFFC)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .reload(reload),
    .count(count), .wrap(wrap)
  );
endmodule

// File: tb/frt_timer_bench.sv
module frt_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rdata1, rdata2;
  logic       ext_pin = 1'b0;
  logic       irq1, irq2;
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  int         rl_edge = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frt_timer u_frt_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .ext_clk_pin(ext_pin), .irq_ovf(irq1)
  );
  frt_timer #(.EXT_PRESENT(0)) u_frt_timer_nopin (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .ext_clk_pin(ext_pin), .irq_ovf(irq2)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 3'd3 || a == 3'd5) rl_edge = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d1,
                    output logic [7:0] d2, output int edge_n);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d1 = rdata1; d2 = rdata2; edge_n = cyc;
  endtask

  task automatic rd_pair(input logic [2:0] ha, output logic [15:0] v1,
                         output logic [15:0] v2, output int hi_edge);
    logic [7:0] h1, h2, l1, l2;
    int e;
    rd(ha, h1, h2, hi_edge);
    rd(ha + 3'd1, l1, l2, e);
    v1 = {h1, l1}; v2 = {h2, l2};
  endtask

  function automatic logic [15:0] exp_cnt(input int re, input int n);
    return 16'hFFFC + 16'((re - 1 - rl_edge) / n);
  endfunction

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulses(input int num);
    for (int i = 0; i < num; i++) begin
      ext_pin = 1'b1; idle(4);
      if (i != num - 1) begin ext_pin = 1'b0; idle(4); end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] d1, d2;
    logic [15:0] v1, v2;
    int e;
    int modes[3] = '{1, 0, 2};
    int divs[3]  = '{2, 4, 8};
    idle(5);
    rst = 1'b0;
    idle(1);
    // R5 reset state
    check("R5 irq after reset", irq1, 0);
    rd(3'd0, d1, d2, e); check("R5 ctrl after reset", d1, 8'h00);
    rd(3'd1, d1, d2, e); check("R5 TOF after reset", d1, 8'h00);

    // R1 R2 R5 R6 R11 sweep over internal dividers, both views
    for (int m = 0; m < 3; m++) begin
      wr(3'd0, 8'(modes[m]));
      rd(3'd0, d1, d2, e); check("R2 ctrl readback", d1, modes[m]);
      wr((m == 0) ? 3'd3 : 3'd5, 8'h5A);
      for (int i = 0; i < 10; i++) begin
        rd_pair(3'd2, v1, v2, e);
        check("R2 R11 main view count", v1, exp_cnt(e, divs[m]));
        rd_pair(3'd4, v1, v2, e);
        check("R6 R1 alt view count", v1, exp_cnt(e, divs[m]));
      end
      // R7 flag set after wrap, R8 alt low read keeps it
      rd(3'd1, d1, d2, e); check("R7 TOF after wrap", d1, 8'h80);
      rd(3'd5, d1, d2, e);
      rd(3'd1, d1, d2, e); check("R8 alt low keeps TOF", d1, 8'h80);
      rd(3'd3, d1, d2, e);
      rd(3'd1, d1, d2, e); check("R8 TOF cleared", d1, 8'h00);
    end

    // R9 overflow between status read and low read
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h00); idle(12);
    rd(3'd1, d1, d2, e); check("R9 TOF set", d1, 8'h80);
    wr(3'd3, 8'h00); idle(12);
    rd(3'd3, d1, d2, e);
    rd(3'd1, d1, d2, e); check("R9 TOF kept", d1, 8'h80);
    rd(3'd3, d1, d2, e);
    rd(3'd1, d1, d2, e); check("R9 TOF cleared later", d1, 8'h00);

    // R10 interrupt
    wr(3'd0, 8'h09);
    check("R10 irq low with TOF clear", irq1, 0);
    wr(3'd3, 8'h00); idle(12);
    check("R10 irq high", irq1, 1);
    rd(3'd1, d1, d2, e); rd(3'd3, d1, d2, e);
    check("R10 irq low after clear", irq1, 0);
    wr(3'd3, 8'h00); idle(12);
    wr(3'd0, 8'h01);
    check("R10 irq masked", irq1, 0);
    rd(3'd1, d1, d2, e); rd(3'd3, d1, d2, e);

    // R3 external rising edges, R4 absent pin
    wr(3'd0, 8'h07); idle(5);
    wr(3'd3, 8'h00);
    pulses(3); idle(5);
    rd_pair(3'd2, v1, v2, e);
    check("R3 rising edge count", v1, 16'hFFFF);
    check("R4 absent pin no count", v2, 16'hFFFC);
    // R3 falling edges
    ext_pin = 1'b0;
    wr(3'd0, 8'h03); idle(5);
    wr(3'd5, 8'h00);
    pulses(3); idle(5);
    rd_pair(3'd4, v1, v2, e);
    check("R3 falling edge count", v1, 16'hFFFE);
    check("R4 absent pin no count falling", v2, 16'hFFFC);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule